// File: doc/BRIEF.md
# Last-Hop-Vertical Route Computation for a Bus-Linked 3D Mesh Router

This unit picks the output port for a packet at one router of a layered mesh. The layers of the mesh are joined by vertical buses. The router has five inputs: the four compass directions and the local processing element. It has six outputs: the same five plus one onto the vertical bus. There is no vertical input, because traffic that arrives from another layer is handed straight to the processing element and never re-enters the router.

The unit compares the header flit's destination coordinates with the router's own coordinates. Every in-layer move is finished before the one vertical move, so the vertical output is only ever the last hop. In-layer moves follow one of two modes:
- A fixed X-then-Y order.
- An adaptive choice. When both in-layer dimensions still need a move, it takes the direction whose neighbouring input queue is shorter.

Optionally, groups of 2×2 nodes share one vertical bus. A packet bound for another layer is then steered to its group's pillar. A packet that stays in the layer is still steered to its exact destination.

The result is computed combinationally. It is captured into a register when a header flit is presented. Body and tail flits reuse the captured port.

Top module: `lastz_route_unit`

## Requirements
- R1: Ports are encoded as East=0, West=1, North=2, South=3, Local=4, Vertical=5. Local is selected when the destination x, y and z all equal the router's own coordinates.
- R2: Vertical is selected only when the destination layer differs from the router's layer and the router's x,y equals the target pillar x,y. It is never selected otherwise.
- R3: While the destination layer differs and the router's x,y is not yet the target pillar x,y, an in-layer port (0..3) is selected.
- R4: In static mode (cfg_adaptive=0), an unresolved X is served first: East when the target x is larger than the router's x, West when it is smaller.
- R5: In static mode, once X is resolved, Y is served: North when the target y is larger, South when it is smaller.
- R6: In adaptive mode, with both X and Y unresolved, the X step is taken when the queue of the X-candidate neighbour is strictly shorter. The Y step is taken when the Y-candidate's queue is strictly shorter. The X candidate is East or West according to the sign of the move; the Y candidate is North or South likewise.
- R7: In adaptive mode, when the two candidate queue lengths are equal, the X step is taken.
- R8: In adaptive mode, when only one in-layer dimension is unresolved, that dimension's direction is taken whatever the queue lengths are.
- R9: With cfg_pillar_share=1, the target pillar x,y is the destination x,y with bit 0 of each cleared. This applies only when the destination layer differs. Same-layer packets route to the exact destination x,y.
- R10: The route is registered: out_port shows the route for the header presented with hdr_valid=1 one clock edge later. While hdr_valid=0, out_port and out_valid hold their values whatever the other inputs do.
- R11: While reset is active and after it, until the first header, out_valid=0 and out_port=Local (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_adaptive | input | 1 | 1 selects queue-aware X/Y choice, 0 selects fixed X-then-Y |
| cfg_pillar_share | input | 1 | 1 makes 2×2 node groups share one vertical bus |
| self_x | input | XW | Router x coordinate |
| self_y | input | YW | Router y coordinate |
| self_z | input | ZW | Router layer |
| hdr_valid | input | 1 | A header flit is presented this cycle |
| dst_x | input | XW | Destination x from the header |
| dst_y | input | YW | Destination y from the header |
| dst_z | input | ZW | Destination layer from the header |
| qlen_east | input | QW | Input queue length of the east neighbour |
| qlen_west | input | QW | Input queue length of the west neighbour |
| qlen_north | input | QW | Input queue length of the north neighbour |
| qlen_south | input | QW | Input queue length of the south neighbour |
| out_port | output | 3 | Registered output port for the current packet |
| out_valid | output | 1 | A header has been captured since reset |

## Verification
The route function is swept over every destination in the default 8×8×8 space. The sweep is repeated from a corner router, an opposite-corner router, a router at an even pillar position and an interior router at odd coordinates, under all four combinations of mode and pillar sharing.
- Corner routers leave only one sign of move, so they separate the East/West and North/South decodes.
- The odd interior router separates pillar-cleared targets from exact ones.
- The even pillar router shows vertical hops taken for whole groups.

Queue lengths vary with the destination so that strict-less cases in both directions and ties all occur, which separates the adaptive comparison, its tie rule and the single-dimension override. Between headers, the destination is changed with hdr_valid low to show that body flits leave the captured port alone.

// File: rtl/lzr_pkg.sv
package lzr_pkg;

  typedef enum logic [2:0] {
    PORT_EAST  = 3'd0,
    PORT_WEST  = 3'd1,
    PORT_NORTH = 3'd2,
    PORT_SOUTH = 3'd3,
    PORT_LOCAL = 3'd4,
    PORT_VERT  = 3'd5
  } port_e;

  // Adaptive tie-break: X wins unless Y's queue is strictly shorter.
  function automatic logic prefer_x(input logic [15:0] qx, input logic [15:0] qy);
    return (qx <= qy);
  endfunction

  // Port for one axis step given its sign.
  function automatic port_e axis_port(input logic is_x, input logic plus);
    if (is_x) return plus ? PORT_EAST : PORT_WEST;
    return plus ? PORT_NORTH : PORT_SOUTH;
  endfunction

endpackage

// File: rtl/lzr_target.sv
module lzr_target #(
  parameter int XW = 3,
  parameter int YW = 3,
  parameter int ZW = 3
) (
  input  logic          share,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  input  logic [ZW-1:0] dst_z,
  input  logic [ZW-1:0] self_z,
  output logic [XW-1:0] tgt_x,
  output logic [YW-1:0] tgt_y,
  output logic          need_z
);
  localparam logic [XW-1:0] XMASK = {{(XW-1){1'b1}}, 1'b0};
  localparam logic [YW-1:0] YMASK = {{(YW-1){1'b1}}, 1'b0};

  always_comb begin
    need_z = (dst_z != self_z);
    if (share && need_z) begin
      tgt_x = dst_x & XMASK;
      tgt_y = dst_y & YMASK;
    end else begin
      tgt_x = dst_x;
      tgt_y = dst_y;
    end
  end
endmodule

// File: rtl/lzr_dir_pick.sv
module lzr_dir_pick
  import lzr_pkg::*;
#(
  parameter int XW = 3,
  parameter int YW = 3,
  parameter int QW = 4
) (
  input  logic          adaptive,
  input  logic [XW-1:0] self_x,
  input  logic [YW-1:0] self_y,
  input  logic [XW-1:0] tgt_x,
  input  logic [YW-1:0] tgt_y,
  input  logic          need_z,
  input  logic [QW-1:0] q_e,
  input  logic [QW-1:0] q_w,
  input  logic [QW-1:0] q_n,
  input  logic [QW-1:0] q_s,
  output logic          x_open,
  output logic          y_open,
  output logic          take_x,
  output port_e         port
);
  logic x_plus, y_plus;
  logic [15:0] qx, qy;

  always_comb begin
    x_open = (tgt_x != self_x);
    y_open = (tgt_y != self_y);
    x_plus = (tgt_x > self_x);
    y_plus = (tgt_y > self_y);
    qx = 16'(x_plus ? q_e : q_w);
    qy = 16'(y_plus ? q_n : q_s);
    if (x_open && y_open && adaptive) take_x = prefer_x(qx, qy);
    else                              take_x = x_open;
    if (!x_open && !y_open) port = need_z ? PORT_VERT : PORT_LOCAL;
    else if (take_x)        port = axis_port(1'b1, x_plus);
    else                    port = axis_port(1'b0, y_plus);
  end
endmodule

// File: rtl/lzr_route_hold.sv
module lzr_route_hold
  import lzr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  port_e port_in,
  output port_e port_q,
  output logic  valid_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_q  <= PORT_LOCAL;
      valid_q <= 1'b0;
    end else if (load) begin
      port_q  <= port_in;
      valid_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lastz_route_unit.sv
module lastz_route_unit
  import lzr_pkg::*;
#(
  parameter int XW = 3,
  parameter int YW = 3,
  parameter int ZW = 3,
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_adaptive,
  input  logic          cfg_pillar_share,
  input  logic [XW-1:0] self_x,
  input  logic [YW-1:0] self_y,
  input  logic [ZW-1:0] self_z,
  input  logic          hdr_valid,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  input  logic [ZW-1:0] dst_z,
  input  logic [QW-1:0] qlen_east,
  input  logic [QW-1:0] qlen_west,
  input  logic [QW-1:0] qlen_north,
  input  logic [QW-1:0] qlen_south,
  output logic [2:0]    out_port,
  output logic          out_valid
);
  // Named internal events for the checker.
  logic [XW-1:0] tgt_x;
  logic [YW-1:0] tgt_y;
  logic          need_z;
  logic          x_open, y_open, take_x;
  port_e         route_now;
  port_e         port_q;

  lzr_target #(.XW(XW), .YW(YW), .ZW(ZW)) u_tgt (
    .share (cfg_pillar_share),
    .dst_x (dst_x),
    .dst_y (dst_y),
    .dst_z (dst_z),
    .self_z(self_z),
    .tgt_x (tgt_x),
    .tgt_y (tgt_y),
    .need_z(need_z)
  );

  lzr_dir_pick #(.XW(XW), .YW(YW), .QW(QW)) u_pick (
    .adaptive(cfg_adaptive),
    .self_x  (self_x),
    .self_y  (self_y),
    .tgt_x   (tgt_x),
    .tgt_y   (tgt_y),
    .need_z  (need_z),
    .q_e     (qlen_east),
    .q_w     (qlen_west),
    .q_n     (qlen_north),
    .q_s     (qlen_south),
    .x_open  (x_open),
    .y_open  (y_open),
    .take_x  (take_x),
    .port    (route_now)
  );

  lzr_route_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (hdr_valid),
    .port_in(route_now),
    .port_q (port_q),
    .valid_q(out_valid)
  );

  assign out_port = port_q;
endmodule

// File: rtl/lzr_route_chk.sv
module lzr_route_chk #(
  parameter int XW = 3,
  parameter int YW = 3,
  parameter int ZW = 3,
  parameter int QW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_adaptive,
  input logic          hdr_valid,
  input logic [XW-1:0] self_x,
  input logic [YW-1:0] self_y,
  input logic [ZW-1:0] self_z,
  input logic [XW-1:0] dst_x,
  input logic [YW-1:0] dst_y,
  input logic [ZW-1:0] dst_z,
  input logic [XW-1:0] tgt_x,
  input logic [YW-1:0] tgt_y,
  input logic          x_open,
  input logic          y_open,
  input logic [2:0]    route_now,
  input logic [2:0]    out_port,
  input logic          out_valid
);
  // R1: local only at the exact destination.
  a_r1_local_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (route_now == 3'd4) |-> (dst_x == self_x && dst_y == self_y && dst_z == self_z));

  // R2: vertical only at the pillar with a layer change.
  a_r2_vert_at_pillar: assert property (@(posedge clk) disable iff (!rst_n)
    (route_now == 3'd5) |-> (dst_z != self_z && tgt_x == self_x && tgt_y == self_y));

  // R3: in-layer ports while off the target column.
  a_r3_inlayer_first: assert property (@(posedge clk) disable iff (!rst_n)
    (x_open || y_open) |-> (route_now <= 3'd3));

  // R4: static mode serves X before Y.
  a_r4_static_x_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_adaptive && x_open) |-> (route_now == 3'd0 || route_now == 3'd1));

  // R8: single open dimension is taken in adaptive mode too.
  a_r8_single_dim: assert property (@(posedge clk) disable iff (!rst_n)
    (!x_open && y_open) |-> (route_now == 3'd2 || route_now == 3'd3));

  // R10: capture on header, hold otherwise.
  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> (out_port == $past(route_now) && out_valid));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> ($stable(out_port) && $stable(out_valid)));

  // R11: nothing valid without a header since reset.
  a_r11_reset_state: assert property (@(posedge clk)
    (!rst_n) |=> (!out_valid && out_port == 3'd4));
endmodule

bind lastz_route_unit lzr_route_chk #(.XW(XW), .YW(YW), .ZW(ZW), .QW(QW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_adaptive(cfg_adaptive),
  .hdr_valid   (hdr_valid),
  .self_x      (self_x),
  .self_y      (self_y),
  .self_z      (self_z),
  .dst_x       (dst_x),
  .dst_y       (dst_y),
  .dst_z       (dst_z),
  .tgt_x       (tgt_x),
  .tgt_y       (tgt_y),
  .x_open      (x_open),
  .y_open      (y_open),
  .route_now   (route_now),
  .out_port    (out_port),
  .out_valid   (out_valid)
);

// File: tb/sim_lastz_route_unit.sv
module sim_lastz_route_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_adaptive = 1'b0, cfg_pillar_share = 1'b0;
  logic [2:0] self_x = '0, self_y = '0, self_z = '0;
  logic       hdr_valid = 1'b0;
  logic [2:0] dst_x = '0, dst_y = '0, dst_z = '0;
  logic [3:0] qlen_east = '0, qlen_west = '0, qlen_north = '0, qlen_south = '0;
  logic [2:0] out_port;
  logic       out_valid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lastz_route_unit u0 (
    .clk(clk), .rst_n(rst_n), .cfg_adaptive(cfg_adaptive),
    .cfg_pillar_share(cfg_pillar_share), .self_x(self_x), .self_y(self_y),
    .self_z(self_z), .hdr_valid(hdr_valid), .dst_x(dst_x), .dst_y(dst_y),
    .dst_z(dst_z), .qlen_east(qlen_east), .qlen_west(qlen_west),
    .qlen_north(qlen_north), .qlen_south(qlen_south),
    .out_port(out_port), .out_valid(out_valid)
  );

  // Independent model. Tag names the requirement governing the case.
  function automatic int model(input int sx, sy, sz, dx, dy, dz, ad, sh,
                               input int qe, qw, qn, qs, output string tag);
    int ex, ey, mx, my;
    ex = dx; ey = dy; tag = "R1";
    if (dz != sz && sh != 0) begin ex = (dx / 2) * 2; ey = (dy / 2) * 2; tag = "R9"; end
    mx = ex - sx; my = ey - sy;
    if (mx == 0 && my == 0) begin
      if (dz == sz) return 4;
      if (tag != "R9") tag = "R2";
      return 5;
    end
    if (dz != sz && tag != "R9") tag = "R3";
    if (ad == 0) begin
      if (mx != 0) begin if (tag == "R1") tag = "R4"; return (mx > 0) ? 0 : 1; end
      if (tag == "R1") tag = "R5";
      return (my > 0) ? 2 : 3;
    end
    if (mx == 0 || my == 0) begin
      if (tag == "R1") tag = "R8";
      if (mx != 0) return (mx > 0) ? 0 : 1;
      return (my > 0) ? 2 : 3;
    end
    begin
      int cx, cy;
      cx = (mx > 0) ? qe : qw;
      cy = (my > 0) ? qn : qs;
      if (tag == "R1") tag = (cx == cy) ? "R7" : "R6";
      if (cx > cy) return (my > 0) ? 2 : 3;
      return (mx > 0) ? 0 : 1;
    end
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int exp;
    int hold_port;
    string tag;
    repeat (3) @(posedge clk);
    #1;
    check("R11", out_valid, 0);
    check("R11", out_port, 4);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R11", out_valid, 0);
    check("R11", out_port, 4);

    for (int mi = 0; mi < 4; mi++) begin
      case (mi)
        0: begin self_x = 3'd0; self_y = 3'd0; self_z = 3'd0; end
        1: begin self_x = 3'd7; self_y = 3'd7; self_z = 3'd7; end
        2: begin self_x = 3'd2; self_y = 3'd4; self_z = 3'd3; end
        default: begin self_x = 3'd3; self_y = 3'd5; self_z = 3'd1; end
      endcase
      for (int md = 0; md < 4; md++) begin
        cfg_adaptive = md[0];
        cfg_pillar_share = md[1];
        for (int d = 0; d < 512; d++) begin
          dst_x = d[2:0]; dst_y = d[5:3]; dst_z = d[8:6];
          qlen_east  = 4'((d * 5 + mi) % 16);
          qlen_west  = 4'((d * 7) % 16);
          qlen_north = 4'((d * 3 + md) % 16);
          qlen_south = 4'((d * 5 + mi + (d % 3)) % 16);
          hdr_valid = 1'b1;
          exp = model(self_x, self_y, self_z, dst_x, dst_y, dst_z, md % 2, md / 2,
                      qlen_east, qlen_west, qlen_north, qlen_south, tag);
          @(posedge clk); #1;
          check(tag, out_port, exp);
          if (d % 16 == 5) begin
            // Body flits: other destinations must not disturb the port.
            hold_port = exp;
            hdr_valid = 1'b0;
            dst_x = ~dst_x; dst_y = ~dst_y; dst_z = ~dst_z;
            qlen_east = ~qlen_east; qlen_north = ~qlen_north;
            @(posedge clk); #1;
            check("R10", out_port, hold_port);
            check("R10", out_valid, 1);
          end
        end
      end
    end

    // Directed tie: both dimensions open, equal queues -> X (R7).
    cfg_adaptive = 1'b1; cfg_pillar_share = 1'b0;
    self_x = 3'd3; self_y = 3'd3; self_z = 3'd2;
    dst_x = 3'd1; dst_y = 3'd6; dst_z = 3'd2;
    qlen_west = 4'd9; qlen_north = 4'd9; qlen_east = 4'd0; qlen_south = 4'd0;
    hdr_valid = 1'b1;
    @(posedge clk); #1;
    check("R7", out_port, 1);
    // Strictly shorter Y queue -> North (R6).
    qlen_north = 4'd8;
    @(posedge clk); #1;
    check("R6", out_port, 2);

    hdr_valid = 1'b0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule